// File: doc/BRIEF.md
# Double-Buffered Bulk IN Transmit Buffer

This block is the transmit store for one bulk IN endpoint. It has two packet banks of up to `PKT_BYTES` bytes each. A local microcontroller loads bytes into one bank through a byte write port. When a packet is complete, the microcontroller commits it with a one-cycle pulse, and further writes then go to the other bank. Meanwhile, the serial engine reads the oldest committed bank byte by byte, starting when a token arrives from the host.

A transmission ends with a done pulse. An acknowledge pulse from the host then frees the bank, with no firmware action needed. If no acknowledge arrives and another token comes, the same bank is sent again from its first byte. Two outputs tell firmware whether it may write: a status bit that is set only when both banks hold committed packets, and an interrupt that is asserted while the interrupt enable is high and at least one bank is free.

Top module: `bulkin_dual_bank`

## Requirements
- R1: After reset both banks are free, writes go to bank 0, transmission starts from bank 0, `rd_valid` and `pkt_rdy` are 0, and `irq` equals `irq_en`.
- R2: Each accepted write stores `wr_data` at the next byte position of the write bank, starting at 0. Writes beyond `PKT_BYTES` bytes in one packet are dropped.
- R3: A `commit` pulse while the write bank is free marks that bank ready, records its byte count as the packet length, and moves writes to the other bank. A `commit` while the write bank is ready is ignored. A write in the same cycle as `commit` is dropped.
- R4: A commit with no bytes written produces a ready packet of length 0. Sending it never raises `rd_valid`, and it is freed by an acknowledge like any other packet.
- R5: An `in_token` while idle and while the transmit bank is ready starts sending that bank from byte 0. While sending, `rd_valid` is 1 exactly when the read position is below the packet length. `rd_data` is the byte at that position when `rd_valid` is 1, and 0 otherwise. An `in_token` during sending is ignored.
- R6: `rd_en` while `rd_valid` is 1 advances the read position by one in the next cycle.
- R7: `tx_done` while sending ends the transmission and the block waits for an acknowledge. `tx_done` at any other time is ignored.
- R8: `host_ack` while waiting clears the ready flag of the transmit bank and moves transmission to the other bank, so packets leave in commit order. `host_ack` at any other time is ignored.
- R9: An `in_token` while waiting, without `host_ack` in the same cycle, sends the same bank again from byte 0. If `host_ack` and `in_token` arrive together, the acknowledge wins and the token is dropped.
- R10: Writes while both banks are ready are ignored and do not change any stored packet.
- R11: `pkt_rdy` is 1 exactly when both banks hold ready packets.
- R12: `irq` is 1 exactly when `irq_en` is 1 and at least one bank is free.
- R13: The free bank may be written and committed while the other bank is being sent. After that bank is acknowledged, the next `in_token` sends the newer packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DATA_W | Byte from the microcontroller |
| wr_en | input | 1 | Write strobe for `wr_data` |
| commit | input | 1 | Packet-ready set pulse for the write bank |
| irq_en | input | 1 | Interrupt enable |
| in_token | input | 1 | Host token pulse: start or repeat a transmission |
| tx_done | input | 1 | End of the current transmission |
| host_ack | input | 1 | Host acknowledge of the transmitted packet |
| rd_en | input | 1 | Byte consumed by the serial engine |
| rd_data | output | DATA_W | Byte at the read position of the transmit bank |
| rd_valid | output | 1 | `rd_data` holds a packet byte |
| pkt_rdy | output | 1 | Firmware-visible packet-ready bit (both banks ready) |
| irq | output | 1 | Active-high interrupt: a bank can take a packet |

## Verification
The bench first sends a single packet through the full cycle. This shows that the bank order and the length recording are right. It then fills the second bank while the first is being read, which separates the write pointer from the transmit pointer and drives `pkt_rdy` and `irq` through their full-buffer values. It also pushes writes against a full buffer. A missing acknowledge followed by a new token checks that the same bytes are sent again from the start. An overlong packet and an empty commit probe both ends of the length range. Coincident pulses (write with commit, acknowledge with token) pin down the stated priorities.

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/bulkin_bank.sv
module bulkin_bank #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 64,
  localparam int ADDR_W   = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  len
);
  logic [DATA_W-1:0] mem [PKT_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      len <= '0;
    else if (len_we) len <= len_in;
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/bulkin_ctrl.sv
module bulkin_ctrl
  import bulkin_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             commit,
  input  logic             in_token,
  input  logic             tx_done,
  input  logic             host_ack,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] tx_len,
  output logic             wbank,
  output logic             tbank,
  output logic [1:0]       ready,
  output logic [CNT_W-1:0] wcount,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             sending,
  output logic             rd_avail,
  output logic             ev_write,
  output logic             ev_commit,
  output logic             ev_start,
  output logic             ev_retry,
  output logic             ev_ack,
  output logic             ev_adv,
  output logic             ev_end
);
  tx_state_e  st;
  logic [1:0] ready_n;

  function automatic logic has_room(input logic [CNT_W-1:0] cnt);
    return cnt < CNT_W'(PKT_BYTES);
  endfunction

  function automatic logic more_left(input logic [CNT_W-1:0] pos,
                                     input logic [CNT_W-1:0] lim);
    return pos < lim;
  endfunction

  assign sending   = (st == TX_SEND);
  assign rd_avail  = sending && more_left(rd_ptr, tx_len);
  assign ev_commit = commit && !ready[wbank];
  assign ev_write  = wr_en && !commit && !ready[wbank] && has_room(wcount);
  assign ev_ack    = host_ack && (st == TX_WAIT);
  assign ev_start  = in_token && (st == TX_IDLE) && ready[tbank];
  assign ev_retry  = in_token && (st == TX_WAIT) && !host_ack;
  assign ev_adv    = rd_en && rd_avail;
  assign ev_end    = tx_done && sending;

  always_comb begin
    ready_n = ready;
    if (ev_commit) ready_n[wbank] = 1'b1;
    if (ev_ack)    ready_n[tbank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank  <= 1'b0;
      tbank  <= 1'b0;
      ready  <= 2'b00;
      wcount <= '0;
      rd_ptr <= '0;
      st     <= TX_IDLE;
    end else begin
      ready <= ready_n;
      if (ev_commit) begin
        wcount <= '0;
        wbank  <= ~wbank;
      end else if (ev_write) begin
        wcount <= wcount + 1'b1;
      end
      if (ev_ack) begin
        tbank <= ~tbank;
        st    <= TX_IDLE;
      end else if (ev_start || ev_retry) begin
        st     <= TX_SEND;
        rd_ptr <= '0;
      end else if (ev_end) begin
        st <= TX_WAIT;
      end else if (ev_adv) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bulkin_dual_bank.sv
module bulkin_dual_bank #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 64,
  localparam int ADDR_W   = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              commit,
  input  logic              irq_en,
  input  logic              in_token,
  input  logic              tx_done,
  input  logic              host_ack,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              pkt_rdy,
  output logic              irq
);
  logic             wbank, tbank, sending, rd_avail;
  logic [1:0]       ready;
  logic [CNT_W-1:0] wcount, rd_ptr, tx_len;
  logic             ev_write, ev_commit, ev_start, ev_retry, ev_ack, ev_adv, ev_end;
  logic [DATA_W-1:0] bank_byte [2];
  logic [CNT_W-1:0]  bank_len  [2];

  bulkin_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .commit(commit),
    .in_token(in_token), .tx_done(tx_done), .host_ack(host_ack),
    .rd_en(rd_en), .tx_len(tx_len), .wbank(wbank), .tbank(tbank),
    .ready(ready), .wcount(wcount), .rd_ptr(rd_ptr), .sending(sending),
    .rd_avail(rd_avail), .ev_write(ev_write), .ev_commit(ev_commit),
    .ev_start(ev_start), .ev_retry(ev_retry), .ev_ack(ev_ack),
    .ev_adv(ev_adv), .ev_end(ev_end)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    bulkin_bank #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ev_write && (wbank == 1'(g))),
      .wr_addr(wcount[ADDR_W-1:0]),
      .wr_data(wr_data),
      .len_we(ev_commit && (wbank == 1'(g))),
      .len_in(wcount),
      .rd_addr(rd_ptr[ADDR_W-1:0]),
      .rd_byte(bank_byte[g]),
      .len(bank_len[g])
    );
  end

  assign tx_len   = bank_len[tbank];
  assign rd_valid = rd_avail;
  assign rd_data  = rd_avail ? bank_byte[tbank] : '0;
  assign pkt_rdy  = &ready;
  assign irq      = irq_en && !(&ready);
endmodule

// File: rtl/bulkin_dual_bank_chk.sv
module bulkin_dual_bank_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             irq,
  input logic             pkt_rdy,
  input logic             rd_valid,
  input logic [1:0]       ready,
  input logic             wbank,
  input logic             tbank,
  input logic [CNT_W-1:0] wcount,
  input logic [CNT_W-1:0] rd_ptr,
  input logic             sending,
  input logic             ev_commit,
  input logic             ev_ack,
  input logic             ev_retry
);
  // R12
  irq_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && !pkt_rdy));

  // R3
  commit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (wbank != $past(wbank)) && ready[$past(wbank)]);

  // R8
  ack_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (tbank != $past(tbank)) && !ready[$past(tbank)]);

  // R9
  retry_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> sending && (rd_ptr == '0));

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready == 2'b11) |=> $stable(wcount));

  // R5
  valid_needs_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> sending);
endmodule

bind bulkin_dual_bank bulkin_dual_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq(irq), .pkt_rdy(pkt_rdy),
  .rd_valid(rd_valid), .ready(ready), .wbank(wbank), .tbank(tbank),
  .wcount(wcount), .rd_ptr(rd_ptr), .sending(sending),
  .ev_commit(ev_commit), .ev_ack(ev_ack), .ev_retry(ev_retry)
);

// File: tb/tb_bulkin_dual_bank.sv
module tb_bulkin_dual_bank;
  localparam int PERIOD = 10;
  localparam int PKT    = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 0, commit = 0, irq_en = 1, in_token = 0;
  logic       tx_done = 0, host_ack = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic       rd_valid, pkt_rdy, irq;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // behavioural reference
  logic [7:0] mq [2][$];
  bit         mrdy [2];
  int         mwb = 0, mtb = 0, mst = 0, mrp = 0;  // mst: 0 idle, 1 send, 2 wait

  always #(PERIOD/2) clk = ~clk;

  bulkin_dual_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
    .commit(commit), .irq_en(irq_en), .in_token(in_token),
    .tx_done(tx_done), .host_ack(host_ack), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .pkt_rdy(pkt_rdy), .irq(irq)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit  e_pkt, e_irq, e_rv;
    int  e_rd;
    e_pkt = mrdy[0] && mrdy[1];
    e_irq = irq_en && !e_pkt;
    e_rv  = (mst == 1) && (mrp < mq[mtb].size());
    e_rd  = e_rv ? int'(mq[mtb][mrp]) : 0;
    chk(pkt_rdy == e_pkt, "pkt_rdy (R11)", pkt_rdy, e_pkt);
    chk(irq == e_irq, "irq (R12)", irq, e_irq);
    chk(rd_valid == e_rv, "rd_valid (R5)", rd_valid, e_rv);
    chk(int'(rd_data) == e_rd, "rd_data (R5)", rd_data, e_rd);
  endtask

  task automatic tick();
    bit ack, retry, start, adv, endt, cm, wr;
    int owb, otb;
    owb   = mwb; otb = mtb;
    ack   = host_ack && mst == 2;
    retry = in_token && mst == 2 && !host_ack;
    start = in_token && mst == 0 && mrdy[otb];
    adv   = rd_en && mst == 1 && mrp < mq[otb].size();
    endt  = tx_done && mst == 1;
    cm    = commit && !mrdy[owb];
    wr    = wr_en && !commit && !mrdy[owb] && mq[owb].size() < PKT;
    @(posedge clk);
    #1;
    if (wr) mq[owb].push_back(wr_data);
    if (cm) begin mrdy[owb] = 1; mwb = owb ^ 1; end
    if (ack) begin
      mrdy[otb] = 0; mq[otb].delete(); mtb = otb ^ 1; mst = 0;
    end else if (start || retry) begin
      mst = 1; mrp = 0;
    end else if (endt) begin
      mst = 2;
    end else if (adv) begin
      mrp++;
    end
    wr_en = 0; commit = 0; in_token = 0; tx_done = 0; host_ack = 0; rd_en = 0;
    compare();
  endtask

  task automatic put(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_data = 8'(base + i * 7); wr_en = 1; tick();
    end
  endtask
  task automatic do_commit(); commit = 1; tick(); endtask
  task automatic token();     in_token = 1; tick(); endtask
  task automatic done();      tx_done = 1; tick(); endtask
  task automatic ack();       host_ack = 1; tick(); endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1; tick(); end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mrdy[0] = 0; mrdy[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    tag = "R1";
    compare();
    chk(irq == 1'b1 && pkt_rdy == 1'b0 && rd_valid == 1'b0, "reset outputs", {irq, pkt_rdy, rd_valid}, 3'b100);

    // R2 R3 R5 R6 R7 R8: one packet through the full cycle
    tag = "R2";  put(5, 8'h10);
    tag = "R5";  token();                       // nothing ready: ignored
    tag = "R3";  do_commit();
    chk(pkt_rdy == 0, "R3 single commit keeps status bit low", pkt_rdy, 0);
    tag = "R8";  ack();                         // idle ack ignored
    tag = "R5";  token();
    chk(rd_valid == 1, "R5 start on token", rd_valid, 1);
    tag = "R6";  drain(2);
    tag = "R5";  token();                       // token while sending ignored
    tag = "R6";  drain(4);
    chk(rd_valid == 0, "R6 end of packet length", rd_valid, 0);
    tag = "R7";  done();
    tag = "R8";  ack();

    // R13 fill the other bank during transmission; R10 R11 R12 R9
    tag = "R13"; put(10, 8'h40); do_commit();
    token(); drain(3);
    put(7, 8'h80); do_commit();
    tag = "R11"; chk(pkt_rdy == 1, "R11 both banks ready", pkt_rdy, 1);
    tag = "R12"; chk(irq == 0, "R12 irq low when full", irq, 1'b0);
    tag = "R10"; put(4, 8'hF0); commit = 1; tick();
    tag = "R13"; drain(2); done();
    tag = "R9";  token();
    chk(int'(rd_data) == int'(8'h40), "R9 resend restarts at byte 0", rd_data, 8'h40);
    drain(10); done(); ack();
    tag = "R13"; token();
    chk(int'(rd_data) == int'(8'h80), "R13 newer packet sent next", rd_data, 8'h80);
    tag = "R10"; drain(8);
    chk(rd_valid == 0, "R10 packet length stayed 7", rd_valid, 0);
    done(); ack();

    // R2 overlong packet is clipped
    tag = "R2";  put(PKT + 6, 8'h03); do_commit(); token(); drain(PKT + 6);
    chk(rd_valid == 0, "R2 clipped at capacity", rd_valid, 0);
    done(); ack();

    // R4 zero-length packet
    tag = "R4";  do_commit(); token();
    chk(rd_valid == 0, "R4 empty packet has no bytes", rd_valid, 0);
    drain(2); done(); ack();
    chk(pkt_rdy == 0 && irq == 1, "R4 bank freed", {pkt_rdy, irq}, 2'b01);

    // R3 write coinciding with commit is dropped
    tag = "R3";  put(2, 8'h21); wr_data = 8'hEE; wr_en = 1; commit = 1; tick();
    token(); drain(3);
    // R9 ack and token together: ack wins
    tag = "R9";  done(); host_ack = 1; in_token = 1; tick();
    chk(rd_valid == 0, "R9 token dropped under ack", rd_valid, 0);

    // R12 interrupt enable low
    tag = "R12"; irq_en = 0; tick();
    chk(irq == 0, "R12 irq gated by enable", irq, 0);
    irq_en = 1; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule